// File: doc/BRIEF.md
# Serial EEPROM Slave, 2 Kbit, Three-Wire Protocol

This block is a synthesizable model of a 2048-bit serial EEPROM that acts as a slave on a Microwire-style three-wire bus: select, serial clock, data in. A fourth wire carries data out, and a separate enable marks when that wire is actively driven. A static strap picks the organization: 128 words of 16 bits, or 256 words of 8 bits. The bus inputs are sampled in the system clock domain, and rising edges of the serial clock are found by edge detection.

A host sends an instruction made of one start bit, a two-bit opcode and an address field. For writes, the data word follows. A read streams words out through the address space for as long as the host keeps clocking. Any command that changes the array is held until select falls. At that point a self-timed write cycle starts. During that cycle, raising select reports busy or ready on the data-out wire. Writes are blocked from reset until software issues a write-enable instruction.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, data-out is not driven (`dout_oe` low), every array word reads as all ones, and writes are disabled.
- R2: With `org16` high, an instruction is 11 bits in this order: a start bit of 1, a 2-bit opcode, then 8 address bits sent MSB first. The low 7 address bits select one of 128 words. Data words are 16 bits, MSB first. Zeros clocked in before the start bit are ignored.
- R3: With `org16` low, an instruction is 12 bits with 9 address bits. The low 8 address bits select one of 256 words, and data words are 8 bits.
- R4: `dout_oe` is low whenever select is low, and also while an instruction or write data is being shifted in.
- R5: Read (opcode 10): after the last address bit, data-out shows one 0 bit. Each further rising serial-clock edge then presents the next data bit, MSB first.
- R6: A read that keeps clocking continues into the next word. After the last word it wraps to word 0.
- R7: Opcode 00 with the top two address bits at 11 sets the write-enable latch, and at 00 clears it. While the latch is clear, write, erase, write-all and erase-all have no effect on the array and start no write cycle.
- R8: Write (opcode 01) replaces the word once the data bits are in and select falls. The write cycle then lasts `WRITE_CYCLES` system clocks.
- R9: With select high after a write cycle starts, data-out is driven: 0 while the cycle runs, 1 once it has ended. Instructions clocked in while the cycle runs are ignored.
- R10: While busy/ready status is shown, a rising serial-clock edge with data-in at 1 stops driving data-out.
- R11: Erase (opcode 11) sets one word to all ones. Opcode 00 with top address bits 10 sets every word to all ones. Opcode 00 with top address bits 01, followed by a data word, writes that word to every location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by the system clock |
| din | input | 1 | Serial data in |
| org16 | input | 1 | Organization strap: 1 = 16-bit words, 0 = 8-bit words |
| dout | output | 1 | Serial data out: read data or ready flag |
| dout_oe | output | 1 | High while `dout` is actively driven |

## Verification
The bench builds the block with `WRITE_CYCLES` set to 120 and two synchronizer stages. This keeps each self-timed cycle short enough to write all 128 sixteen-bit words one by one, then read the whole array back in one sequential stream that wraps past the end. In byte mode it writes every fourth location and streams all 256 bytes. The short cycle also leaves room to clock a full instruction in while a write is still running, so the busy-time lockout can be checked.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM slave.
// Assumes: one package per compile, imported by every mw_* module.
package mw_pkg;

    // Protocol sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_WAIT
    } mw_state_e;

    // Array-changing operation waiting for select to fall
    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_WRAL,
        OP_ERAL
    } mw_op_e;

endpackage

// File: rtl/mw_in_sync.sv
// Synchronizes select, serial clock and data in into the system clock
// domain, and flags a rising serial-clock edge and a falling select edge.
// Assumes: STAGES >= 2; all three inputs share the same latency.
module mw_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    output logic cs_s,
    output logic din_s,
    output logic sk_rise,
    output logic cs_fall
);
    logic [STAGES-1:0] cs_p, sk_p, di_p;
    logic              sk_prev, cs_prev;

    // Shift each input through its synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p <= '0;
            sk_p <= '0;
            di_p <= '0;
            sk_prev <= 1'b0;
            cs_prev <= 1'b0;
        end else begin
            cs_p    <= {cs_p[STAGES-2:0], cs};
            sk_p    <= {sk_p[STAGES-2:0], sclk};
            di_p    <= {di_p[STAGES-2:0], din};
            sk_prev <= sk_p[STAGES-1];
            cs_prev <= cs_p[STAGES-1];
        end
    end

    // Edge flags from the synchronized levels
    always_comb begin
        cs_s    = cs_p[STAGES-1];
        din_s   = di_p[STAGES-1];
        sk_rise = sk_p[STAGES-1] & ~sk_prev;
        cs_fall = ~cs_p[STAGES-1] & cs_prev;
    end
endmodule

// File: rtl/mw_write_timer.sv
// Self-timed write cycle: busy for CYCLES clocks after start, then a
// one-cycle done pulse.
// Assumes: start only arrives while not busy; CYCLES >= 2.
module mw_write_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    // Count down the cycle and pulse done at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                left <= CW'(CYCLES - 1);
                busy <= 1'b1;
            end else if (busy) begin
                if (left == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mw_mem_array.sv
// Byte-wide register array that resets to all ones. In 16-bit mode word a
// sits in bytes 2a (high half) and 2a+1 (low half).
// Assumes: BYTES = 256, so 8-bit addresses cover the array exactly.
module mw_mem_array #(
    parameter int BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        org16,
    input  logic        wr_en,
    input  logic        wr_all,
    input  logic [7:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data
);
    logic [7:0] mem [BYTES];

    // Update every byte the current write covers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            for (int i = 0; i < BYTES; i++) begin
                if (org16) begin
                    if (wr_all || (i / 2 == int'(wr_addr[6:0])))
                        mem[i] <= (i % 2 == 0) ? wr_data[15:8] : wr_data[7:0];
                end else begin
                    if (wr_all || (i == int'(wr_addr)))
                        mem[i] <= wr_data[7:0];
                end
            end
        end
    end

    // Assemble the addressed word for the reader
    always_comb begin
        if (org16) rd_data = {mem[{rd_addr[6:0], 1'b0}], mem[{rd_addr[6:0], 1'b1}]};
        else       rd_data = {8'h00, mem[rd_addr]};
    end
endmodule

// File: rtl/mw_eeprom.sv
// Serial EEPROM slave, 2 Kbit, 16-bit or 8-bit words chosen by org16.
// Decodes start/opcode/address, streams sequential reads, holds the
// write-enable latch, launches self-timed writes on select falling and
// reports busy/ready on data out.
// Assumes: org16 is static; serial clock is slow against clk.
module mw_eeprom #(
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    input  logic org16,
    output logic dout,
    output logic dout_oe
);
    import mw_pkg::*;

    localparam int ARRAY_BITS = 2048;
    localparam int BYTES      = ARRAY_BITS / 8;

    logic        cs_s, din_s, sk_rise, cs_fall;
    logic        busy, wr_done, wr_start;
    mw_state_e   state;
    mw_op_e      pend_op;
    logic [9:0]  cmd_sh;
    logic [10:0] cmd_word;
    logic [4:0]  cnt;
    logic [4:0]  cmd_last, data_last;
    logic [1:0]  op_bits, sel_bits;
    logic [7:0]  waddr, addr_q, pend_addr, next_addr;
    logic [15:0] data_sh, rd_data, wr_data;
    logic [3:0]  bit_idx;
    logic        wen_q, status_q, dout_q, in_read;

    mw_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
        .cs_s(cs_s), .din_s(din_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_write_timer #(.CYCLES(WRITE_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(wr_done)
    );

    mw_mem_array #(.BYTES(BYTES)) i_mem (
        .clk(clk), .rst_n(rst_n), .org16(org16), .wr_en(wr_done),
        .wr_all(pend_op == OP_WRAL || pend_op == OP_ERAL),
        .wr_addr(pend_addr), .wr_data(wr_data),
        .rd_addr(addr_q), .rd_data(rd_data)
    );

    // Field extraction from the instruction as its last bit arrives
    always_comb begin
        cmd_word  = {cmd_sh, din_s};
        cmd_last  = org16 ? 5'd9 : 5'd10;
        data_last = org16 ? 5'd15 : 5'd7;
        op_bits   = org16 ? cmd_word[9:8] : cmd_word[10:9];
        sel_bits  = org16 ? cmd_word[7:6] : cmd_word[8:7];
        waddr     = org16 ? {1'b0, cmd_word[6:0]} : cmd_word[7:0];
        next_addr = org16 ? {1'b0, addr_q[6:0] + 7'd1} : addr_q + 8'd1;
        bit_idx   = data_last[3:0] - cnt[3:0];
        wr_data   = (pend_op == OP_ERASE || pend_op == OP_ERAL) ? 16'hFFFF :
                    (org16 ? data_sh : {8'h00, data_sh[7:0]});
        in_read   = (state == ST_READ);
        wr_start  = cs_fall && (state == ST_WAIT) && (pend_op != OP_NONE) && wen_q && !busy;
        dout      = in_read ? dout_q : ~busy;
        dout_oe   = cs_s && (in_read || status_q);
    end

    // Protocol sequencer: instruction, data, read stream, write launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_op   <= OP_NONE;
            cmd_sh    <= '0;
            cnt       <= '0;
            addr_q    <= '0;
            pend_addr <= '0;
            data_sh   <= '0;
            wen_q     <= 1'b0;
            status_q  <= 1'b0;
            dout_q    <= 1'b0;
        end else begin
            if (cs_fall) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else if (sk_rise && cs_s) begin
                case (state)
                    ST_IDLE: if (din_s && !busy && !status_q) begin
                        state <= ST_CMD;
                        cnt   <= '0;
                    end
                    ST_CMD: begin
                        cmd_sh <= cmd_word[9:0];
                        cnt    <= cnt + 5'd1;
                        if (cnt == cmd_last) begin
                            cnt       <= '0;
                            pend_op   <= OP_NONE;
                            pend_addr <= waddr;
                            state     <= ST_WAIT;
                            case (op_bits)
                                2'b10: begin
                                    state  <= ST_READ;
                                    addr_q <= waddr;
                                    dout_q <= 1'b0;
                                end
                                2'b01: begin
                                    state   <= ST_DATA;
                                    pend_op <= OP_WRITE;
                                end
                                2'b11: pend_op <= OP_ERASE;
                                default: case (sel_bits)
                                    2'b11: wen_q <= 1'b1;
                                    2'b00: wen_q <= 1'b0;
                                    2'b10: pend_op <= OP_ERAL;
                                    default: begin
                                        state   <= ST_DATA;
                                        pend_op <= OP_WRAL;
                                    end
                                endcase
                            endcase
                        end
                    end
                    ST_DATA: begin
                        data_sh <= {data_sh[14:0], din_s};
                        cnt     <= cnt + 5'd1;
                        if (cnt == data_last) state <= ST_WAIT;
                    end
                    ST_READ: begin
                        dout_q <= rd_data[bit_idx];
                        cnt    <= cnt + 5'd1;
                        if (cnt == data_last) begin
                            cnt    <= '0;
                            addr_q <= next_addr;
                        end
                    end
                    default: ;
                endcase
            end
            if (sk_rise && cs_s && din_s && status_q) status_q <= 1'b0;
            if (wr_start) status_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
// Property checker for mw_eeprom, attached by the bind below.
// Assumes: WRITE_CYCLES >= 2.
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic din_s,
    input logic sk_rise,
    input logic busy,
    input logic wr_start,
    input logic wen_q,
    input logic status_q,
    input logic in_read,
    input logic dout,
    input logic dout_oe
);
    // R4: data out is only driven while selected
    a_r4_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> cs_s);

    // R9: while the cycle runs the driven status reads low
    a_r9_busy_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && busy && !in_read) |-> !dout);

    // R9: no read stream can run during a write cycle
    a_r9_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_read);

    // R7: a write cycle only launches with the latch set
    a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> wen_q);

    // R8: a started cycle stays busy past its first clock
    a_r8_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R10: a one clocked in during status releases data out
    a_r10_dummy_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_rise && cs_s && din_s && status_q && !in_read) |=> !dout_oe);
endmodule

bind mw_eeprom mw_eeprom_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .din_s(din_s), .sk_rise(sk_rise),
    .busy(busy), .wr_start(wr_start), .wen_q(wen_q), .status_q(status_q),
    .in_read(in_read), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_mw_eeprom.sv
// Self-checking bench: full 16-bit sweep, byte-mode sweep, protocol corners.
module test_mw_eeprom;
    localparam int HALF = 3;
    localparam int WC   = 120;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0, org16 = 1'b1;
    logic dout, dout_oe;
    int   n_chk = 0, n_err = 0;
    logic [15:0] m16 [128];
    logic [7:0]  m8  [256];

    mw_eeprom #(.WRITE_CYCLES(WC), .SYNC_STAGES(2)) i_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
        .org16(org16), .dout(dout), .dout_oe(dout_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din = b;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic cs_on();
        cs = 1'b1;
        wait_clk(6);
    endtask

    task automatic cs_off();
        cs = 1'b0;
        din = 1'b0;
        wait_clk(6);
    endtask

    task automatic instr(input logic [1:0] op, input logic [8:0] a);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int k = (org16 ? 7 : 8); k >= 0; k--) send_bit(a[k]);
    endtask

    task automatic send_data(input logic [15:0] v);
        for (int k = (org16 ? 15 : 7); k >= 0; k--) send_bit(v[k]);
    endtask

    // Status phase after select fell on a modifying command
    task automatic status_phase(input bit exp_busy);
        cs_on();
        if (exp_busy) begin
            check(dout_oe && dout == 1'b0, "R9 busy low", {dout_oe, dout}, 2'b10);
            wait_clk(WC + 10);
            check(dout_oe && dout == 1'b1, "R9 ready high", {dout_oe, dout}, 2'b11);
            send_bit(1'b1);
            check(!dout_oe, "R10 dummy one releases", dout_oe, 0);
        end else begin
            check(!dout_oe, "R7 no cycle while disabled", dout_oe, 0);
        end
        cs_off();
    endtask

    task automatic do_write(input int a, input logic [15:0] v, input bit en);
        cs_on();
        instr(2'b01, 9'(a));
        send_data(v);
        check(!dout_oe, "R4 quiet during input", dout_oe, 0);
        cs_off();
        status_phase(en);
        if (en) begin
            if (org16) m16[a % 128] = v;
            else       m8[a % 256]  = v[7:0];
        end
    endtask

    task automatic do_special(input logic [8:0] a16, input logic [8:0] a8);
        cs_on();
        instr(2'b00, org16 ? a16 : a8);
        cs_off();
    endtask

    task automatic read_seq(input int a, input int n, input string req);
        cs_on();
        instr(2'b10, 9'(a));
        check(dout_oe && dout == 1'b0, "R5 leading zero", {dout_oe, dout}, 2'b10);
        for (int w = 0; w < n; w++) begin
            logic [15:0] got = '0;
            logic [15:0] exp;
            for (int b = 0; b < (org16 ? 16 : 8); b++) begin
                send_bit(1'b0);
                got = {got[14:0], dout};
            end
            exp = org16 ? m16[(a + w) % 128] : {8'h00, m8[(a + w) % 256]};
            check(got == exp, req, int'(got), int'(exp));
        end
        cs_off();
    endtask

    function automatic logic [15:0] pat16(input int a);
        return 16'((a * 40503) ^ (a << 9) ^ 16'h5AC3);
    endfunction

    // Watchdog: a hung run is a failure that still reports
    initial begin
        wait_clk(190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) m16[i] = 16'hFFFF;
        for (int i = 0; i < 256; i++) m8[i] = 8'hFF;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check(!dout_oe, "R1 reset oe", dout_oe, 0);
        read_seq(0, 2, "R1 reset contents");

        // R7: writes and erase are blocked from reset
        do_write(5, 16'h1234, 1'b0);
        cs_on(); instr(2'b11, 9'd6); cs_off();
        status_phase(1'b0);
        read_seq(5, 1, "R7 blocked write");

        // R2: leading zeros then write enable
        cs_on(); send_bit(1'b0); send_bit(1'b0); instr(2'b00, 9'h0C0); cs_off();
        check(!dout_oe, "R4 deselected", dout_oe, 0);

        // R8: every 16-bit word with its own pattern
        for (int a = 0; a < 128; a++) do_write(a, pat16(a), 1'b1);
        read_seq(0, 130, "R6 sequential with wrap");
        read_seq(126, 4, "R6 wrap at end");

        // R11: single-word erase
        cs_on(); instr(2'b11, 9'd3); cs_off();
        status_phase(1'b1);
        m16[3] = 16'hFFFF;
        read_seq(2, 3, "R11 erase one");

        // R9: instruction during busy is ignored (a disable that must not take)
        cs_on(); instr(2'b01, 9'd40); send_data(16'hAAAA); cs_off();
        cs_on();
        check(dout_oe && dout == 1'b0, "R9 busy low", {dout_oe, dout}, 2'b10);
        send_bit(1'b1);
        instr(2'b00, 9'h000);
        cs_off();
        wait_clk(WC + 10);
        m16[40] = 16'hAAAA;
        do_write(41, 16'h1357, 1'b1);
        read_seq(40, 2, "R9 busy ignore");

        // R11: write-all then erase-all
        cs_on(); instr(2'b00, 9'h040); send_data(16'hC3A5); cs_off();
        status_phase(1'b1);
        for (int i = 0; i < 128; i++) m16[i] = 16'hC3A5;
        read_seq(0, 128, "R11 write all");
        do_special(9'h080, 9'h100);
        status_phase(1'b1);
        for (int i = 0; i < 128; i++) m16[i] = 16'hFFFF;
        read_seq(0, 128, "R11 erase all");

        // R7: disable, then write-all and write are ignored
        do_special(9'h000, 9'h000);
        cs_on(); instr(2'b00, 9'h040); send_data(16'h0000); cs_off();
        status_phase(1'b0);
        do_write(9, 16'h0F0F, 1'b0);
        read_seq(8, 3, "R7 disabled");

        // R3: byte organization
        org16 = 1'b0;
        wait_clk(4);
        do_special(9'h0C0, 9'h180);
        do_special(9'h080, 9'h100);
        status_phase(1'b1);
        for (int a = 1; a < 256; a += 4) do_write(a, {8'h00, 8'(a * 37 + 11)}, 1'b1);
        read_seq(0, 258, "R3 byte sweep");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule